// File: doc/BRIEF.md
# Labeled Timeline Event Scheduler

This block separates a front end that produces work at an irregular pace from an output that must act on exact cycles. The writer fills two queues. One holds timing points, each an interval length paired with a label. The other holds micro-operation words, each tagged with a label. The timeline exists only as a chain of intervals between consecutive points; no absolute timestamps are stored.

Once started, the block counts down one interval at a time. When the current interval expires, it places that point's label on a broadcast bus for one cycle. In that same cycle it releases every queued micro-operation at the head of the event queue whose label matches, on parallel output lanes. Events sharing a label are expected to be written next to each other. An elaboration parameter chooses whether the first timing point is launched by a start command or by an external trigger.

The writer can stall, burst or trickle. This does not move any broadcast, provided the timing queue still holds the next point when it is needed.

Top module: `tl_event_sched`

## Requirements
- R1: After reset, `bcast_valid`, every `ev_valid` lane, `underrun`, `tq_full`, `eq_full` and `eq_level` are all 0.
- R2: With `START_SEL`=0, only `start_cmd` launches the timeline and `ext_trig` has no effect. With `START_SEL`=1, only `ext_trig` launches it and `start_cmd` has no effect.
- R3: A launch sampled at clock edge E makes the first broadcast visible in the cycle that follows edge E+L-1, where L is the head entry's effective interval. Each later broadcast comes exactly its own effective interval after the previous one, whatever the timing of the writes.
- R4: Each broadcast raises `bcast_valid` for one cycle and drives the label of the expiring point on `bcast_lbl`. The number of broadcasts equals the number of timing points consumed.
- R5: In a broadcast cycle, the head events whose label equals the broadcast label are emitted in queue order: the oldest on lane 0, the next on lane 1, and so on. Lane i is used only if lanes 0 to i-1 are also used.
- R6: At most `LANES` events leave per broadcast. Matching events beyond that limit stay queued and go out on a later broadcast with the same label.
- R7: An event at the head whose label does not match stays queued and blocks the events behind it. `eq_level` reports the number of events held, and it falls only by the number of events fired.
- R8: An interval value of 0 behaves as an interval of 1 cycle.
- R9: If the timing queue is empty when a point expires, or when a launch arrives, `underrun` goes to 1 in the next cycle and broadcasts stop. Pushing alone does not resume the timeline. A launch with a non-empty timing queue resumes it and clears `underrun`.
- R10: `tq_full` and `eq_full` are 1 while their queue holds `TQ_DEPTH` or `EQ_DEPTH` entries. A push while full is dropped and does not change the queue's contents or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tq_push | input | 1 | Write one timing point |
| tq_ivl | input | IVL_W | Interval in cycles (0 treated as 1) |
| tq_lbl | input | LBL_W | Label of the timing point |
| tq_full | output | 1 | Timing queue full |
| eq_push | input | 1 | Write one event |
| eq_op | input | OP_W | Micro-operation word |
| eq_lbl | input | LBL_W | Label the event waits for |
| eq_full | output | 1 | Event queue full |
| eq_level | output | $clog2(EQ_DEPTH+1) | Events currently held |
| start_cmd | input | 1 | Launch by command (START_SEL=0) |
| ext_trig | input | 1 | Launch by external trigger (START_SEL=1) |
| bcast_valid | output | 1 | A timing point expired this cycle |
| bcast_lbl | output | LBL_W | Label of the expiring point |
| ev_valid | output | LANES | Per-lane fire strobe |
| ev_op | output | LANES*OP_W | Fired micro-operations, lane 0 in low bits |
| underrun | output | 1 | Sticky: timing queue ran dry |

## Verification
The main function is tried with a preloaded mixed timeline. It holds a zero interval, back-to-back one-cycle points, a long gap and a repeated label. Absolute broadcast cycles separate a correct interval chain from off-by-one counting, and the repeated label shows that events are matched by label rather than by position. A second run feeds timing points while the timeline is already running and then lets the timing queue drain, which separates write timing from output timing and exercises the stall and resume path. A third run queues more same-label events than there are lanes, plus a stranded event. This shows lane ordering, the per-broadcast cap and head blocking, and a fourth run overfills both queues to show that dropped pushes never reach the output.

// File: rtl/tl_sched_pkg.sv
package tl_sched_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HALT = 2'd2
   } tl_state_t;

   localparam int START_BY_CMD  = 0;
   localparam int START_BY_TRIG = 1;

endpackage

// File: rtl/tl_fifo.sv
module tl_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   parameter int PEEK  = 1,
   localparam int AW   = $clog2(DEPTH),
   localparam int LVW  = $clog2(DEPTH + 1),
   localparam int PCW  = $clog2(PEEK + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [W-1:0]      wdata,
   input  logic [PCW-1:0]    pop_n,
   output logic [PEEK*W-1:0] head,
   output logic [LVW-1:0]    level,
   output logic              full
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tl_fifo: DEPTH must be a power of two of at least 2");
   end
   if (PEEK < 1 || PEEK > DEPTH) begin : g_bad_peek
      $error("tl_fifo: PEEK must lie in 1..DEPTH");
   end

   logic [W-1:0]   mem [DEPTH];
   logic [AW-1:0]  rd_q, wr_q;
   logic [LVW-1:0] lvl_q;
   logic           push_ok;

   assign full    = (lvl_q == LVW'(DEPTH));
   assign push_ok = push && !full;
   assign level   = lvl_q;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_q] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (push_ok) wr_q <= wr_q + AW'(1);
         rd_q  <= rd_q + AW'(pop_n);
         lvl_q <= lvl_q + LVW'(push_ok) - LVW'(pop_n);
      end
   end

   for (genvar i = 0; i < PEEK; i++) begin : g_peek
      assign head[i*W +: W] = mem[rd_q + AW'(i)];
   end

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> lvl_q <= $past(lvl_q));

   // R6
   pop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pop_n) <= int'(lvl_q));

endmodule

// File: rtl/tl_timer.sv
module tl_timer
   import tl_sched_pkg::*;
#(
   parameter int IVL_W     = 8,
   parameter int LBL_W     = 4,
   parameter int START_SEL = START_BY_CMD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_cmd,
   input  logic             ext_trig,
   input  logic             tq_empty,
   input  logic [IVL_W-1:0] head_ivl,
   input  logic [LBL_W-1:0] head_lbl,
   output logic             tq_pop,
   output logic             bcast_valid,
   output logic [LBL_W-1:0] bcast_lbl,
   output logic             underrun
);

   tl_state_t        state_q;
   logic [IVL_W-1:0] cnt_q;
   logic [LBL_W-1:0] lbl_q;
   logic             urun_q;
   logic             start_evt, expire, launch, take;
   logic [IVL_W-1:0] ivl_eff;

   if (START_SEL == START_BY_CMD) begin : g_cmd_start
      assign start_evt = start_cmd;
      logic unused_trig;
      assign unused_trig = ext_trig;
   end else begin : g_trig_start
      assign start_evt = ext_trig;
      logic unused_cmd;
      assign unused_cmd = start_cmd;
   end

   assign expire  = (state_q == ST_RUN) && (cnt_q == IVL_W'(1));
   assign launch  = (state_q != ST_RUN) && start_evt;
   assign take    = (expire || launch) && !tq_empty;
   assign ivl_eff = (head_ivl == '0) ? IVL_W'(1) : head_ivl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         lbl_q   <= '0;
         urun_q  <= 1'b0;
      end else if (take) begin
         state_q <= ST_RUN;
         cnt_q   <= ivl_eff;
         lbl_q   <= head_lbl;
         urun_q  <= 1'b0;
      end else if (expire || launch) begin
         state_q <= ST_HALT;
         urun_q  <= 1'b1;
      end else if (state_q == ST_RUN) begin
         cnt_q   <= cnt_q - IVL_W'(1);
      end
   end

   assign tq_pop      = take;
   assign bcast_valid = expire;
   assign bcast_lbl   = lbl_q;
   assign underrun    = urun_q;

   // R9
   halt_no_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      urun_q |-> !bcast_valid);

   // R9
   underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      urun_q && !start_evt |=> urun_q);

   // R3
   gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_valid && !tq_empty && head_ivl > IVL_W'(1) |=> !bcast_valid);

   // R8
   zero_ivl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_valid && !tq_empty && head_ivl == '0 |=> bcast_valid);

endmodule

// File: rtl/tl_release.sv
module tl_release #(
   parameter int OP_W  = 8,
   parameter int LBL_W = 4,
   parameter int LANES = 2,
   parameter int LVW   = 4,
   localparam int EW   = OP_W + LBL_W,
   localparam int PCW  = $clog2(LANES + 1)
) (
   input  logic               bcast_valid,
   input  logic [LBL_W-1:0]   bcast_lbl,
   input  logic [LANES*EW-1:0] head,
   input  logic [LVW-1:0]     level,
   output logic [LANES-1:0]   ev_valid,
   output logic [LANES*OP_W-1:0] ev_op,
   output logic [PCW-1:0]     pop_n
);

   logic [LANES-1:0] match, fire;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [EW-1:0] ent;
      assign ent      = head[i*EW +: EW];
      assign match[i] = bcast_valid && (level > LVW'(i)) &&
                        (ent[LBL_W-1:0] == bcast_lbl);
      assign ev_op[i*OP_W +: OP_W] = ent[EW-1:LBL_W];
      if (i == 0) begin : g_first
         assign fire[i] = match[i];
      end else begin : g_next
         assign fire[i] = match[i] && fire[i-1];
      end
   end

   always_comb begin
      pop_n = '0;
      for (int i = 0; i < LANES; i++) pop_n = pop_n + PCW'(fire[i]);
   end

   assign ev_valid = fire;

endmodule

// File: rtl/tl_event_sched.sv
module tl_event_sched
   import tl_sched_pkg::*;
#(
   parameter int OP_W      = 8,
   parameter int LBL_W     = 4,
   parameter int IVL_W     = 8,
   parameter int TQ_DEPTH  = 8,
   parameter int EQ_DEPTH  = 8,
   parameter int LANES     = 2,
   parameter int START_SEL = START_BY_CMD
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tq_push,
   input  logic [IVL_W-1:0]              tq_ivl,
   input  logic [LBL_W-1:0]              tq_lbl,
   output logic                          tq_full,
   input  logic                          eq_push,
   input  logic [OP_W-1:0]               eq_op,
   input  logic [LBL_W-1:0]              eq_lbl,
   output logic                          eq_full,
   output logic [$clog2(EQ_DEPTH+1)-1:0] eq_level,
   input  logic                          start_cmd,
   input  logic                          ext_trig,
   output logic                          bcast_valid,
   output logic [LBL_W-1:0]              bcast_lbl,
   output logic [LANES-1:0]              ev_valid,
   output logic [LANES*OP_W-1:0]         ev_op,
   output logic                          underrun
);

   localparam int TW   = IVL_W + LBL_W;
   localparam int EW   = OP_W + LBL_W;
   localparam int TLVW = $clog2(TQ_DEPTH + 1);
   localparam int ELVW = $clog2(EQ_DEPTH + 1);
   localparam int PCW  = $clog2(LANES + 1);

   if (LANES < 1 || LANES > EQ_DEPTH) begin : g_bad_lanes
      $error("tl_event_sched: LANES must lie in 1..EQ_DEPTH");
   end
   if (START_SEL != START_BY_CMD && START_SEL != START_BY_TRIG) begin : g_bad_sel
      $error("tl_event_sched: START_SEL must be 0 or 1");
   end

   logic [TW-1:0]       tq_head;
   logic [TLVW-1:0]     tq_level;
   logic                tq_pop;
   logic [LANES*EW-1:0] eq_head;
   logic [PCW-1:0]      eq_pop_n;

   tl_fifo #(.W(TW), .DEPTH(TQ_DEPTH), .PEEK(1)) i_tq (
      .clk, .rst_n,
      .push  (tq_push),
      .wdata ({tq_ivl, tq_lbl}),
      .pop_n (tq_pop),
      .head  (tq_head),
      .level (tq_level),
      .full  (tq_full)
   );

   tl_fifo #(.W(EW), .DEPTH(EQ_DEPTH), .PEEK(LANES)) i_eq (
      .clk, .rst_n,
      .push  (eq_push),
      .wdata ({eq_op, eq_lbl}),
      .pop_n (eq_pop_n),
      .head  (eq_head),
      .level (eq_level),
      .full  (eq_full)
   );

   tl_timer #(.IVL_W(IVL_W), .LBL_W(LBL_W), .START_SEL(START_SEL)) i_timer (
      .clk, .rst_n,
      .start_cmd, .ext_trig,
      .tq_empty    (tq_level == '0),
      .head_ivl    (tq_head[TW-1:LBL_W]),
      .head_lbl    (tq_head[LBL_W-1:0]),
      .tq_pop      (tq_pop),
      .bcast_valid (bcast_valid),
      .bcast_lbl   (bcast_lbl),
      .underrun    (underrun)
   );

   tl_release #(.OP_W(OP_W), .LBL_W(LBL_W), .LANES(LANES), .LVW(ELVW)) i_rel (
      .bcast_valid, .bcast_lbl,
      .head     (eq_head),
      .level    (eq_level),
      .ev_valid (ev_valid),
      .ev_op    (ev_op),
      .pop_n    (eq_pop_n)
   );

   // R7
   level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> int'(eq_level) == int'($past(eq_level)) + int'($past(eq_push && !eq_full))
                                  - $countones($past(ev_valid)));

   // R7
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bcast_valid |=> eq_level >= $past(eq_level));

endmodule

// File: tb/test_tl_event_sched.sv
module test_tl_event_sched;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic       tq_push = 0, eq_push = 0, start_cmd = 0, ext_trig = 0;
   logic [7:0] tq_ivl = 0, eq_op = 0;
   logic [3:0] tq_lbl = 0, eq_lbl = 0;
   logic       tq_full, eq_full, bcast_valid, underrun;
   logic [3:0] eq_level, bcast_lbl;
   logic [1:0] ev_valid;
   logic [15:0] ev_op;

   tl_event_sched i_tl_event_sched (
      .clk, .rst_n, .tq_push, .tq_ivl, .tq_lbl, .tq_full,
      .eq_push, .eq_op, .eq_lbl, .eq_full, .eq_level,
      .start_cmd, .ext_trig, .bcast_valid, .bcast_lbl,
      .ev_valid, .ev_op, .underrun
   );

   logic       x_tq_push = 0, x_start = 0, x_trig = 0;
   logic [7:0] x_ivl = 0;
   logic [3:0] x_lbl = 0;
   logic       x_tq_full, x_eq_full, x_bv, x_ur;
   logic [3:0] x_level, x_blbl;
   logic [1:0] x_evv;
   logic [15:0] x_evop;

   tl_event_sched #(.START_SEL(1)) i_tl_event_sched_x (
      .clk, .rst_n, .tq_push(x_tq_push), .tq_ivl(x_ivl), .tq_lbl(x_lbl),
      .tq_full(x_tq_full), .eq_push(1'b0), .eq_op(8'h00), .eq_lbl(4'h0),
      .eq_full(x_eq_full), .eq_level(x_level), .start_cmd(x_start),
      .ext_trig(x_trig), .bcast_valid(x_bv), .bcast_lbl(x_blbl),
      .ev_valid(x_evv), .ev_op(x_evop), .underrun(x_ur)
   );

   int errs = 0, nchk = 0;
   int nb = 0, nf = 0, stray = 0, x_nb = 0, x_bcyc = 0, x_blast = 0;
   int bc_cyc [32];
   int bc_lbl [32];
   int fo_op [32];
   int fo_bc [32];

   // ivl in high byte, label in low nibble
   localparam logic [15:0] TP_TAB [5] = '{16'h0301, 16'h0002, 16'h0103, 16'h0504, 16'h0201};
   // op in high byte, label in low nibble
   localparam logic [15:0] EV_TAB [6] = '{16'h1101, 16'h1201, 16'h2102, 16'h3103, 16'h3203, 16'h1401};
   localparam int EXP_OP [6] = '{'h11, 'h12, 'h21, 'h31, 'h32, 'h14};
   localparam int EXP_BC [6] = '{0, 0, 1, 2, 2, 4};

   always @(negedge clk) begin
      if (rst_n) begin
         if (bcast_valid) begin
            if (nb < 32) begin
               bc_cyc[nb] = cyc;
               bc_lbl[nb] = int'(bcast_lbl);
            end
            for (int l = 0; l < 2; l++) begin
               if (ev_valid[l] && nf < 32) begin
                  fo_op[nf] = int'(ev_op[l*8 +: 8]);
                  fo_bc[nf] = nb;
                  nf++;
               end
            end
            nb++;
         end else if (|ev_valid) begin
            stray++;
         end
         if (x_bv) begin
            x_nb++;
            x_bcyc = cyc;
            x_blast = int'(x_blbl);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      nb = 0; nf = 0; stray = 0;
      @(negedge clk);
   endtask

   task automatic push_tp(input int ivl, input int lbl);
      tq_push = 1'b1; tq_ivl = 8'(ivl); tq_lbl = 4'(lbl);
      @(negedge clk);
      tq_push = 1'b0;
   endtask

   task automatic push_ev(input int op, input int lbl);
      eq_push = 1'b1; eq_op = 8'(op); eq_lbl = 4'(lbl);
      @(negedge clk);
      eq_push = 1'b0;
   endtask

   task automatic do_start(output int c0);
      start_cmd = 1'b1;
      c0 = cyc;
      @(negedge clk);
      start_cmd = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errs++;
      $display("FAIL R3: watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      int c0, c1, t;
      @(negedge clk);
      do_reset();

      // R1 reset state
      chk("R1 bcast_valid", int'(bcast_valid), 0);
      chk("R1 ev_valid", int'(ev_valid), 0);
      chk("R1 underrun", int'(underrun), 0);
      chk("R1 tq_full", int'(tq_full), 0);
      chk("R1 eq_full", int'(eq_full), 0);
      chk("R1 eq_level", int'(eq_level), 0);

      // Table walk: mixed timeline, irregular write gaps
      for (int k = 0; k < 6; k++) begin
         push_ev(int'(EV_TAB[k][15:8]), int'(EV_TAB[k][3:0]));
         if (k < 5) begin
            push_tp(int'(TP_TAB[k][15:8]), int'(TP_TAB[k][3:0]));
            repeat (k % 3) @(negedge clk);
         end
      end
      do_start(c0);
      wait_cyc(c0 + 20);
      t = c0;
      for (int k = 0; k < 5; k++) begin
         t += (TP_TAB[k][15:8] == 0) ? 1 : int'(TP_TAB[k][15:8]);
         chk((TP_TAB[k][15:8] == 0) ? "R8 zero interval time" : "R3 bcast time", bc_cyc[k], t);
         chk("R4 bcast label", bc_lbl[k], int'(TP_TAB[k][3:0]));
      end
      chk("R4 bcast count", nb, 5);
      chk("R5 fired count", nf, 6);
      for (int k = 0; k < 6; k++) begin
         chk("R5 fired op", fo_op[k], EXP_OP[k]);
         chk("R5 fired slot", fo_bc[k], EXP_BC[k]);
      end
      chk("R5 no stray fire", stray, 0);
      chk("R9 underrun after drain", int'(underrun), 1);

      // Writes continue while running, then queue drains
      do_reset();
      push_tp(4, 5);
      do_start(c0);
      push_tp(4, 6);
      repeat (3) @(negedge clk);
      push_tp(4, 7);
      wait_cyc(c0 + 12);
      chk("R9 no underrun while fed", int'(underrun), 0);
      wait_cyc(c0 + 13);
      chk("R9 underrun set", int'(underrun), 1);
      wait_cyc(c0 + 24);
      chk("R3 fed bcast 0", bc_cyc[0], c0 + 4);
      chk("R3 fed bcast 1", bc_cyc[1], c0 + 8);
      chk("R3 fed bcast 2", bc_cyc[2], c0 + 12);
      chk("R9 halted count", nb, 3);
      push_tp(2, 8);
      repeat (4) @(negedge clk);
      chk("R9 push alone no resume", nb, 3);
      chk("R9 still underrun", int'(underrun), 1);
      do_start(c1);
      chk("R9 cleared on restart", int'(underrun), 0);
      wait_cyc(c1 + 5);
      chk("R9 resumed bcast time", bc_cyc[3], c1 + 2);
      chk("R9 resumed label", bc_lbl[3], 8);

      // Lane cap, head blocking, ignored trigger
      do_reset();
      push_ev('h91, 9); push_ev('h92, 9); push_ev('h93, 9); push_ev('hA1, 10);
      push_tp(2, 9); push_tp(2, 9); push_tp(1, 11);
      ext_trig = 1'b1;
      @(negedge clk);
      ext_trig = 1'b0;
      repeat (5) @(negedge clk);
      chk("R2 ext_trig ignored", nb, 0);
      do_start(c0);
      wait_cyc(c0 + 3);
      chk("R6 level after capped fire", int'(eq_level), 2);
      wait_cyc(c0 + 10);
      chk("R6 fired total", nf, 3);
      chk("R6 lane0 op", fo_op[0], 'h91);
      chk("R6 lane1 op", fo_op[1], 'h92);
      chk("R6 overflow op", fo_op[2], 'h93);
      chk("R6 overflow slot", fo_bc[2], 1);
      chk("R7 stranded level", int'(eq_level), 1);
      chk("R7 bcast count", nb, 3);

      // Overfill both queues
      do_reset();
      for (int k = 0; k < 10; k++) push_ev(k, 3);
      chk("R10 eq_full", int'(eq_full), 1);
      chk("R10 eq_level capped", int'(eq_level), 8);
      for (int k = 0; k < 9; k++) push_tp(1, k);
      chk("R10 tq_full", int'(tq_full), 1);
      do_start(c0);
      wait_cyc(c0 + 14);
      chk("R10 dropped point absent", nb, 8);
      chk("R10 last label", bc_lbl[7], 7);
      chk("R6 level after one match", int'(eq_level), 6);

      // Trigger-launched variant
      x_ivl = 8'd3; x_lbl = 4'd2; x_tq_push = 1'b1;
      @(negedge clk);
      x_tq_push = 1'b0;
      x_start = 1'b1;
      @(negedge clk);
      x_start = 1'b0;
      repeat (6) @(negedge clk);
      chk("R2 start_cmd ignored", x_nb, 0);
      x_trig = 1'b1;
      c0 = cyc;
      @(negedge clk);
      x_trig = 1'b0;
      wait_cyc(c0 + 6);
      chk("R2 trigger launch count", x_nb, 1);
      chk("R2 trigger launch time", x_bcyc, c0 + 3);
      chk("R2 trigger label", x_blast, 2);

      finish_run();
   end

endmodule